// File: doc/BRIEF.md
# Timer Count Read-Back and Snapshot Unit

This block is the host-facing read path of a multi-channel 16-bit down-counting timer. A narrow host bus gives a 2-bit address, a read strobe, a write strobe and an 8-bit write data byte. Each counter is a free-running 16-bit down-counter with its own clock enable and a two-write byte loader. The block keeps, for each channel, the pointer that picks which byte the next read returns. It also keeps a snapshot register and a flag that marks the snapshot as pending.

A host that must see a coherent 16-bit value can do either of two things. It can stop the counter through its enable and read the two bytes directly. It can also write a snapshot command to the control address, which freezes a copy of the chosen counter while the counter keeps running. Reads of that channel then return the copy until its high byte has been taken. While a channel's two-byte read is unfinished, load writes to that channel are refused and flagged.

The host strobes are plain single-cycle requests with no back-pressure: every strobe is acted on in the cycle it is seen. The read result appears on the cycle after the strobe, qualified by `rd_valid`, and no ready signal exists. Read and write strobes in the same cycle are handled independently. Both are evaluated against the state held before that clock edge.

Top module: `tmr_readback`

## Requirements
- R1: A read strobe with address 0, 1 or 2 selects channel 0, 1 or 2. One cycle later `rd_valid` is high for exactly one cycle and `rd_data` carries the selected byte; at all other times `rd_data` is zero.
- R2: A read strobe at address 3 (the control address) returns no count: one cycle later `rd_valid` stays low, `rd_data` is zero and `rd_illegal` pulses for one cycle.
- R3: Each channel has its own byte pointer. Reads of one channel alternate low byte (bits 7:0) first, then high byte (bits 15:8), starting from low after reset.
- R4: A write to address 3 with data bits 5:4 equal to 00 is a snapshot command for the channel in data bits 7:6. Bits 3:0 are ignored, and a select value of 3 does nothing. The snapshot holds the count present in the cycle of the command.
- R5: An enabled counter decrements by one every cycle and wraps from 0x0000 to 0xFFFF. A snapshot command does not stop or alter it.
- R6: While a snapshot is pending, reads of that channel return the snapshot bytes. The read that returns the high byte releases it, and later reads return the live count.
- R7: A snapshot command for a channel whose snapshot is still pending is ignored, and the first snapshot is kept.
- R8: A count is loaded by two writes to the channel's address, low byte first and then high byte. The new value replaces the count on the edge of the second write and overrides that cycle's decrement.
- R9: A load write to a channel whose read sequence is unfinished is dropped, and `load_err` pulses one cycle later. Unfinished means, before that edge, either the byte pointer is at the high byte or a snapshot is pending. A dropped write does not advance the load byte order.
- R10: A control-address write with data bits 5:4 not equal to 00 changes no count, snapshot or pointer.
- R11: A counter whose enable is low holds its value, so two direct reads return one coherent value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_en | input | NCH | Per-channel count enable |
| bus_addr | input | 2 | Host address: channel number, or 3 for control |
| bus_rd | input | 1 | Read strobe, one cycle per byte |
| bus_wr | input | 1 | Write strobe, one cycle per byte |
| bus_wdata | input | BW | Write data byte |
| rd_data | output | BW | Read byte, registered |
| rd_valid | output | 1 | Read result valid pulse |
| rd_illegal | output | 1 | Pulse for a read at the control address |
| load_err | output | 1 | Pulse for a load write that was refused |

## Verification
The bench builds the block with its defaults: three channels and 8-bit bytes, which gives 16-bit counters. With these values all three channel decodes and the illegal control-address read can be reached. A wrap from 0x0000 to 0xFFFF can be set up with a single load of 0x0001. A reference model of counts, snapshots and pointers is compared with every output on every clock, through directed sequences and a random mix of strobes. That mix often lands snapshot commands, partial reads and loads on the same channel in close succession.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  localparam int unsigned ADDR_W = 2;
  localparam logic [ADDR_W-1:0] CTRL_ADDR = 2'b11;
  localparam logic [1:0] RW_SNAPSHOT = 2'b00;

  typedef struct packed {
    logic [1:0] sel;
    logic [1:0] rw;
    logic [3:0] rsvd;
  } ctrl_word_t;

  function automatic logic is_snapshot(input ctrl_word_t cw);
    return cw.rw == RW_SNAPSHOT;
  endfunction

endpackage

// File: rtl/tmr_chan.sv
module tmr_chan #(
  parameter int unsigned BW = 8,
  localparam int unsigned CW = 2 * BW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          ld_byte_we,
  input  logic [BW-1:0] ld_byte,
  output logic [CW-1:0] count
);

  logic          wptr_hi;
  logic [BW-1:0] stage;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count   <= '0;
      wptr_hi <= 1'b0;
      stage   <= '0;
    end else if (ld_byte_we && wptr_hi) begin
      count   <= {ld_byte, stage};
      wptr_hi <= 1'b0;
    end else begin
      if (ld_byte_we) begin
        stage   <= ld_byte;
        wptr_hi <= 1'b1;
      end
      if (en) count <= count - 1'b1;
    end
  end

  p_count_dec_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !(ld_byte_we && wptr_hi)) |=> count == CW'($past(count) - 1'b1));

  p_count_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !ld_byte_we) |=> $stable(count));

endmodule

// File: rtl/tmr_rdlatch.sv
module tmr_rdlatch #(
  parameter int unsigned BW = 8,
  localparam int unsigned CW = 2 * BW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cnt,
  input  logic          rd_hit,
  input  logic          snap_req,
  output logic [BW-1:0] rd_byte,
  output logic          busy
);

  logic [CW-1:0] hold;
  logic          snapped;
  logic          rptr_hi;
  logic [CW-1:0] src;

  assign src     = snapped ? hold : cnt;
  assign rd_byte = rptr_hi ? src[CW-1:BW] : src[BW-1:0];
  assign busy    = rptr_hi | snapped;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold    <= '0;
      snapped <= 1'b0;
      rptr_hi <= 1'b0;
    end else begin
      if (rd_hit) rptr_hi <= ~rptr_hi;
      if (snap_req && !snapped) begin
        snapped <= 1'b1;
        hold    <= cnt;
      end else if (rd_hit && rptr_hi && snapped) begin
        snapped <= 1'b0;
      end
    end
  end

  p_hold_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    snapped |=> $stable(hold));

  p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (snapped && rd_hit && rptr_hi) |=> !snapped);

  p_second_snap_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (snapped && snap_req && !(rd_hit && rptr_hi)) |=> snapped && $stable(hold));

  p_snap_takes_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (snap_req && !snapped) |=> snapped && hold == $past(cnt));

endmodule

// File: rtl/tmr_bus_dec.sv
module tmr_bus_dec
  import tmr_pkg::*;
#(
  parameter int unsigned NCH = 3,
  parameter int unsigned BW  = 8
) (
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [BW-1:0]     bus_wdata,
  input  logic [NCH-1:0]    busy,
  output logic [NCH-1:0]    rd_hit,
  output logic [NCH-1:0]    snap_req,
  output logic [NCH-1:0]    ld_we,
  output logic              rd_ctrl,
  output logic              ld_drop
);

  ctrl_word_t     cw;
  logic           ctrl_wr;
  logic [NCH-1:0] ld_req;

  assign cw      = ctrl_word_t'(bus_wdata[7:0]);
  assign ctrl_wr = bus_wr && (bus_addr == CTRL_ADDR);
  assign rd_ctrl = bus_rd && (bus_addr == CTRL_ADDR);

  for (genvar c = 0; c < NCH; c++) begin : g_dec
    assign rd_hit[c]   = bus_rd && (bus_addr == ADDR_W'(c));
    assign ld_req[c]   = bus_wr && (bus_addr == ADDR_W'(c));
    assign snap_req[c] = ctrl_wr && is_snapshot(cw) && (cw.sel == 2'(c));
    assign ld_we[c]    = ld_req[c] && !busy[c];
  end

  assign ld_drop = |(ld_req & busy);

endmodule

// File: rtl/tmr_readback.sv
module tmr_readback
  import tmr_pkg::*;
#(
  parameter int unsigned NCH = 3,
  parameter int unsigned BW  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    cnt_en,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [BW-1:0]     bus_wdata,
  output logic [BW-1:0]     rd_data,
  output logic              rd_valid,
  output logic              rd_illegal,
  output logic              load_err
);

  localparam int unsigned CW = 2 * BW;

  logic [NCH-1:0] rd_hit, snap_req, ld_we, busy;
  logic           rd_ctrl, ld_drop;
  logic [CW-1:0]  count [NCH];
  logic [BW-1:0]  chan_byte [NCH];
  logic [BW-1:0]  rd_mux;

  tmr_bus_dec #(.NCH(NCH), .BW(BW)) u_dec (
    .bus_addr (bus_addr),
    .bus_rd   (bus_rd),
    .bus_wr   (bus_wr),
    .bus_wdata(bus_wdata),
    .busy     (busy),
    .rd_hit   (rd_hit),
    .snap_req (snap_req),
    .ld_we    (ld_we),
    .rd_ctrl  (rd_ctrl),
    .ld_drop  (ld_drop)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    tmr_chan #(.BW(BW)) u_chan (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (cnt_en[c]),
      .ld_byte_we(ld_we[c]),
      .ld_byte   (bus_wdata),
      .count     (count[c])
    );

    tmr_rdlatch #(.BW(BW)) u_rdl (
      .clk     (clk),
      .rst_n   (rst_n),
      .cnt     (count[c]),
      .rd_hit  (rd_hit[c]),
      .snap_req(snap_req[c]),
      .rd_byte (chan_byte[c]),
      .busy    (busy[c])
    );
  end

  always_comb begin
    rd_mux = '0;
    for (int c = 0; c < NCH; c++) begin
      if (rd_hit[c]) rd_mux = chan_byte[c];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data    <= '0;
      rd_valid   <= 1'b0;
      rd_illegal <= 1'b0;
      load_err   <= 1'b0;
    end else begin
      rd_data    <= rd_mux;
      rd_valid   <= |rd_hit;
      rd_illegal <= rd_ctrl;
      load_err   <= ld_drop;
    end
  end

  p_legal_rd_valid_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr != CTRL_ADDR && int'(bus_addr) < NCH) |=> rd_valid);

  p_illegal_rd_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == CTRL_ADDR) |=> (!rd_valid && rd_illegal && rd_data == '0));

  p_idle_data_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |-> rd_data == '0);

  p_drop_needs_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> !load_err);

endmodule

// File: tb/sim_tmr_readback.sv
`timescale 1ns/1ps
module sim_tmr_readback;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] cnt_en;
  logic [1:0] bus_addr;
  logic       bus_rd, bus_wr;
  logic [7:0] bus_wdata;
  logic [7:0] rd_data;
  logic       rd_valid, rd_illegal, load_err;

  always #4 clk = ~clk;

  tmr_readback u0 (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .bus_addr(bus_addr),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .rd_data(rd_data), .rd_valid(rd_valid), .rd_illegal(rd_illegal),
    .load_err(load_err)
  );

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;
  string phase = "R1 reset";

  // behavioural reference model
  logic [15:0] m_cnt [3];
  logic [15:0] m_hold [3];
  bit          m_snap [3];
  bit          m_rp [3];
  bit          m_wp [3];
  logic [7:0]  m_stg [3];
  logic [7:0]  e_data;
  bit          e_valid, e_ill, e_err;
  logic [15:0] o_cnt [3];
  bit          o_snap [3];
  bit          o_rp [3];
  bit          set_snap [3];
  bit          do_load [3];
  logic [15:0] src;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 3; i++) begin
        m_cnt[i] = 0; m_hold[i] = 0; m_snap[i] = 0;
        m_rp[i] = 0; m_wp[i] = 0; m_stg[i] = 0;
      end
      e_data = 0; e_valid = 0; e_ill = 0; e_err = 0;
    end else begin
      for (int i = 0; i < 3; i++) begin
        o_cnt[i] = m_cnt[i]; o_snap[i] = m_snap[i]; o_rp[i] = m_rp[i];
        set_snap[i] = 0; do_load[i] = 0;
      end
      e_data = 0; e_valid = 0; e_ill = 0; e_err = 0;
      if (bus_rd) begin
        if (bus_addr == 3) e_ill = 1;
        else begin
          src = o_snap[bus_addr] ? m_hold[bus_addr] : o_cnt[bus_addr];
          e_data = o_rp[bus_addr] ? src[15:8] : src[7:0];
          e_valid = 1;
        end
      end
      if (bus_wr) begin
        if (bus_addr == 3) begin
          if (bus_wdata[5:4] == 0 && bus_wdata[7:6] != 3 && !o_snap[bus_wdata[7:6]])
            set_snap[bus_wdata[7:6]] = 1;
        end else if (o_snap[bus_addr] || o_rp[bus_addr]) begin
          e_err = 1;
        end else if (!m_wp[bus_addr]) begin
          m_stg[bus_addr] = bus_wdata; m_wp[bus_addr] = 1;
        end else begin
          do_load[bus_addr] = 1; m_wp[bus_addr] = 0;
        end
      end
      for (int i = 0; i < 3; i++) begin
        if (do_load[i]) m_cnt[i] = {bus_wdata, m_stg[i]};
        else if (cnt_en[i]) m_cnt[i] = o_cnt[i] - 16'd1;
      end
      if (bus_rd && bus_addr != 3) begin
        m_rp[bus_addr] = !o_rp[bus_addr];
        if (o_rp[bus_addr] && o_snap[bus_addr]) m_snap[bus_addr] = 0;
      end
      for (int i = 0; i < 3; i++) begin
        if (set_snap[i]) begin m_snap[i] = 1; m_hold[i] = o_cnt[i]; end
      end
    end
  end

  // compare every output on every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      checks++;
      if (rd_data !== e_data || rd_valid !== e_valid ||
          rd_illegal !== e_ill || load_err !== e_err) begin
        failures++;
        $display("FAIL %s: actual data=%02h v=%b ill=%b err=%b expected data=%02h v=%b ill=%b err=%b",
                 phase, rd_data, rd_valid, rd_illegal, load_err, e_data, e_valid, e_ill, e_err);
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic rd_op(input logic [1:0] a);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic wr_op(input logic [1:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cnt_en = 3'b000; bus_addr = 2'd0;
    bus_rd = 1'b0; bus_wr = 1'b0; bus_wdata = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    phase = "R1 reset";
    rd_op(2'd0); chk("R1 reset read valid", rd_valid, 1); chk("R1 reset read data", rd_data, 8'h00);
    rd_op(2'd0);

    phase = "R8 load";
    wr_op(2'd0, 8'h34); wr_op(2'd0, 8'h12);
    wr_op(2'd1, 8'hCD); wr_op(2'd1, 8'hAB);
    wr_op(2'd2, 8'h02); wr_op(2'd2, 8'h01);

    phase = "R3 byte order";
    rd_op(2'd0); chk("R3 low byte", rd_data, 8'h34);
    rd_op(2'd0); chk("R3 high byte", rd_data, 8'h12);
    phase = "R1 channel select";
    rd_op(2'd2); chk("R1 ch2 low", rd_data, 8'h02);
    rd_op(2'd2); chk("R1 ch2 high", rd_data, 8'h01);

    phase = "R2 illegal read";
    rd_op(2'd3);
    chk("R2 illegal flag", rd_illegal, 1); chk("R2 no valid", rd_valid, 0); chk("R2 data zero", rd_data, 0);

    phase = "R11 halted read";
    rd_op(2'd1); chk("R11 halted low", rd_data, 8'hCD);
    idle(4);
    rd_op(2'd1); chk("R11 halted high", rd_data, 8'hAB);

    phase = "R5 R4 snapshot while counting";
    cnt_en = 3'b010;
    idle(3);
    wr_op(2'd3, 8'h4F);            // snapshot ch1, low bits ignored
    idle(5);
    phase = "R7 second snapshot ignored";
    wr_op(2'd3, 8'h43);
    idle(3);
    phase = "R6 snapshot reads";
    rd_op(2'd1); idle(2); rd_op(2'd1);
    phase = "R6 live after release";
    rd_op(2'd1); rd_op(2'd1);

    phase = "R9 load refused";
    cnt_en = 3'b000;
    rd_op(2'd2);
    wr_op(2'd2, 8'h55); chk("R9 error after partial read", load_err, 1);
    rd_op(2'd2);
    wr_op(2'd3, 8'h80);
    wr_op(2'd2, 8'h66); chk("R9 error while snapshot pending", load_err, 1);
    rd_op(2'd2); rd_op(2'd2);
    wr_op(2'd2, 8'h77); chk("R9 accepted after finish", load_err, 0);
    wr_op(2'd2, 8'h00);
    rd_op(2'd2); chk("R9 R8 loaded low", rd_data, 8'h77);
    rd_op(2'd2); chk("R9 R8 loaded high", rd_data, 8'h00);

    phase = "R10 non-snapshot control word";
    cnt_en = 3'b001;
    wr_op(2'd3, 8'h30); wr_op(2'd3, 8'h1F); wr_op(2'd3, 8'hC0);
    rd_op(2'd0); rd_op(2'd0);
    cnt_en = 3'b000;

    phase = "R5 wrap";
    wr_op(2'd0, 8'h01); wr_op(2'd0, 8'h00);
    cnt_en = 3'b001;
    idle(2);
    cnt_en = 3'b000;
    rd_op(2'd0); chk("R5 wrap low", rd_data, 8'hFF);
    rd_op(2'd0); chk("R5 wrap high", rd_data, 8'hFF);

    phase = "R8 load while counting";
    cnt_en = 3'b111;
    wr_op(2'd1, 8'h10); idle(2); wr_op(2'd1, 8'h20);
    rd_op(2'd1); rd_op(2'd1);

    phase = "R1 R3 R4 R6 R7 R9 random mix";
    for (int k = 0; k < 4000; k++) begin
      int op;
      op = $urandom_range(0, 9);
      cnt_en = 3'($urandom);
      bus_addr = 2'($urandom);
      bus_wdata = 8'($urandom);
      if ($urandom_range(0, 1) == 0) bus_wdata[5:4] = 2'b00;
      bus_rd = (op < 4) || (op == 9);
      bus_wr = (op >= 4 && op < 7) || (op == 9);
      @(negedge clk);
      bus_rd = 1'b0; bus_wr = 1'b0;
    end
    idle(2);

    finished = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule